// File: doc/BRIEF.md
# Posted-Store Buffer with Read Overtaking

This block sits between a write-through data cache and main memory. Stores from the cache are posted into a small FIFO and written to memory in the background, so the processor does not wait on each memory write. A read miss does not queue behind these posted stores. It takes the memory port ahead of them, which keeps the miss latency short.

Overtaking is only safe when the read cannot pick up stale data. When a read is accepted, its word address is compared against every pending entry and against a store accepted in the same cycle. If any of them match, the read is answered from the youngest matching store one cycle later, and no memory read is issued. If none match, the read is sent to memory, where no pending store can hold newer data for that word.

A single memory request port is shared by the drain and the read refills. A request is accepted when valid and ready are both high. Read data comes back later on a separate response strobe. Only one read is in flight at any time.

Top module: `wbuf_bypass`

## Requirements
- R1: While reset is asserted and right after it, the buffer is empty. `st_ready` and `rd_ready` are 1, and `mem_req_valid` and `rd_resp_valid` are 0.
- R2: An accepted store (`st_valid` and `st_ready` both 1) is held in a FIFO of DEPTH entries (default 4). When no read is being issued, the oldest entry is offered as a write request (`mem_req_write`=1). It leaves the buffer when `mem_req_ready` is 1, and memory receives stores in their arrival order.
- R3: With DEPTH entries held, `st_ready` is 0 and a store offered in that state is discarded without any effect.
- R4: A read that matches nothing goes into an issuing state in the cycle after acceptance. In that state it drives `mem_req_valid`=1 with `mem_req_write`=0 and its address, ahead of any pending write, and it holds that request until `mem_req_ready` is 1.
- R5: A read whose address matches one or more buffered entries gets `rd_resp_valid`=1 in the next cycle, carrying the data of the youngest matching entry. No memory read is issued for it.
- R6: A store and a read to the same address accepted in the same cycle: the store counts as older, and its data is forwarded to the read.
- R7: For a read served by memory, `rd_resp_valid` and `rd_resp_data` follow `mem_rsp_valid` and `mem_rsp_data` in the same cycle.
- R8: `rd_ready` is 0 from the acceptance of a read until the cycle after its response, so at most one read is outstanding.
- R9: While a read waits for memory data, pending stores keep draining.
- R10: Every read returns the data of the latest store to that address accepted no later than the read. This holds when another address that maps to the same cache index intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| rd_valid | input | 1 | Read miss offered |
| rd_ready | output | 1 | Read can be accepted |
| rd_addr | input | AW | Read word address |
| rd_resp_valid | output | 1 | Read data valid |
| rd_resp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | AW | Memory request address |
| mem_req_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DW | Memory read data |

## Verification
A forwarded read answers exactly one cycle after it is accepted. A read that misses the buffer puts its memory request on the port one cycle after acceptance. Its response appears in the same cycle as the memory strobe. `st_ready` falls in the cycle after the entry that fills the buffer is pushed. The bench advances a behavioural model at each rising edge and compares every output against it 2 ns after the falling edge, so each result is sampled in the cycle where it is due. End to end, each returned value is compared with the latest store to that address, and after a final drain memory is compared with those same stores.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_FWD   = 2'd1,
    RD_ISSUE = 2'd2,
    RD_WAIT  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/wbuf_fifo.sv
`timescale 1ns/1ps
module wbuf_fifo #(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int DEPTH = 4
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [AW-1:0]                push_addr,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [AW-1:0]                head_addr,
  output logic [DW-1:0]                head_data,
  output logic [$clog2(DEPTH+1)-1:0]   fill,
  output logic                         full,
  output logic                         empty,
  input  logic [AW-1:0]                lookup_addr,
  output logic                         hit,
  output logic [DW-1:0]                hit_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] idx_c;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (push) tail_d = (tail_q == LAST) ? '0 : tail_q + PW'(1);
    if (pop)  head_d = (head_q == LAST) ? '0 : head_q + PW'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  // scan oldest to youngest; a later match overrides an earlier one
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    idx_c    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx_c = PW'((int'(head_q) + k) % DEPTH);
      if (CW'(k) < cnt_q && addr_q[idx_c] == lookup_addr) begin
        hit      = 1'b1;
        hit_data = data_q[idx_c];
      end
    end
  end

  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];
  assign fill      = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt_q < CW'(DEPTH));
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
  p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> fill == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/wbuf_rdctl.sv
`timescale 1ns/1ps
module wbuf_rdctl
  import wbuf_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  input  logic          st_fire,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          buf_hit,
  input  logic [DW-1:0] buf_hit_data,
  input  logic          mem_gnt,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          issue,
  output logic [AW-1:0] issue_addr,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data
);
  rd_state_e     state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] fwd_q, fwd_d;
  logic          accept, same_cyc, any_hit;

  assign accept   = rd_valid && (state_q == RD_IDLE);
  assign same_cyc = st_fire && (st_addr == rd_addr);
  assign any_hit  = same_cyc || buf_hit;
  assign fwd_d    = same_cyc ? st_data : buf_hit_data;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RD_IDLE:  if (accept) state_d = any_hit ? RD_FWD : RD_ISSUE;
      RD_FWD:   state_d = RD_IDLE;
      RD_ISSUE: if (mem_gnt) state_d = RD_WAIT;
      RD_WAIT:  if (mem_rsp_valid) state_d = RD_IDLE;
      default:  state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RD_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      fwd_q  <= '0;
    end else if (accept) begin
      addr_q <= rd_addr;
      fwd_q  <= fwd_d;
    end
  end

  assign rd_ready      = (state_q == RD_IDLE);
  assign issue         = (state_q == RD_ISSUE);
  assign issue_addr    = addr_q;
  assign rd_resp_valid = (state_q == RD_FWD) || (state_q == RD_WAIT && mem_rsp_valid);
  assign rd_resp_data  = (state_q == RD_FWD) ? fwd_q : mem_rsp_data;

  p_fwd_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && buf_hit && !same_cyc) |=> rd_resp_valid && rd_resp_data == $past(buf_hit_data));
  p_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && same_cyc) |=> rd_resp_valid && rd_resp_data == $past(st_data));
  p_issue_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !mem_gnt) |=> issue && $stable(issue_addr));
  p_one_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid |=> rd_ready);
  p_miss_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !any_hit) |=> issue && !rd_ready);
endmodule

// File: rtl/wbuf_bypass.sv
`timescale 1ns/1ps
module wbuf_bypass
  import wbuf_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int DEPTH = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam int CW = $clog2(DEPTH+1);

  logic          push, pop, full, empty, issue, buf_hit;
  logic [CW-1:0] fill;
  logic [AW-1:0] head_addr, issue_addr;
  logic [DW-1:0] head_data, buf_hit_data;

  assign st_ready      = !full;
  assign push          = st_valid && st_ready;
  assign pop           = !issue && !empty && mem_req_ready;
  assign mem_req_valid = issue || !empty;
  assign mem_req_write = !issue;
  assign mem_req_addr  = issue ? issue_addr : head_addr;
  assign mem_req_wdata = head_data;

  wbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(st_addr), .push_data(st_data),
    .pop(pop), .head_addr(head_addr), .head_data(head_data),
    .fill(fill), .full(full), .empty(empty),
    .lookup_addr(rd_addr), .hit(buf_hit), .hit_data(buf_hit_data)
  );

  wbuf_rdctl #(.AW(AW), .DW(DW)) u_rdctl (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .st_fire(push), .st_addr(st_addr), .st_data(st_data),
    .buf_hit(buf_hit), .buf_hit_data(buf_hit_data),
    .mem_gnt(mem_req_ready), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .issue(issue), .issue_addr(issue_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data)
  );

  p_read_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> mem_req_valid && !mem_req_write && mem_req_addr == issue_addr);
  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(DEPTH)) |-> !st_ready);
  p_drain_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && !mem_req_ready && !rd_valid) |=>
      mem_req_valid && $stable(mem_req_addr));
endmodule

// File: tb/sim_wbuf_bypass.sv
`timescale 1ns/1ps
module sim_wbuf_bypass;
  localparam int AW = 12, DW = 32, DEPTH = 4, LAT = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic st_valid, rd_valid, mem_req_ready, mem_rsp_valid;
  logic [AW-1:0] st_addr, rd_addr;
  logic [DW-1:0] st_data, mem_rsp_data;
  logic st_ready, rd_ready, rd_resp_valid, mem_req_valid, mem_req_write;
  logic [DW-1:0] rd_resp_data, mem_req_wdata;
  logic [AW-1:0] mem_req_addr;

  always #4 clk = ~clk;

  wbuf_bypass #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int nchecks = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [AW-1:0] q_a[$];
  logic [DW-1:0] q_d[$];
  int m_st;                     // 0 idle, 1 fwd, 2 issue, 3 wait
  logic [AW-1:0] m_raddr;
  logic [DW-1:0] m_fdata, exp_rd;
  logic [DW-1:0] arch [int];
  logic [DW-1:0] bmem [int];
  logic e_st_ready, e_rd_ready, e_mv, e_mw, e_rv;
  logic [AW-1:0] e_ma;
  logic [DW-1:0] e_md, e_rd;
  logic d_mv, d_mw;
  logic [AW-1:0] d_ma;
  logic [DW-1:0] d_md, pdata;
  bit pend;
  int dly;

  function automatic void calc();
    e_st_ready = (q_a.size() < DEPTH);
    e_rd_ready = (m_st == 0);
    e_mv = (m_st == 2) || (q_a.size() > 0);
    e_mw = (m_st != 2);
    e_ma = (m_st == 2) ? m_raddr : ((q_a.size() > 0) ? q_a[0] : '0);
    e_md = (q_d.size() > 0) ? q_d[0] : '0;
    e_rv = (m_st == 1) || (m_st == 3 && mem_rsp_valid);
    e_rd = (m_st == 1) ? m_fdata : mem_rsp_data;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_a.delete(); q_d.delete(); m_st = 0; pend = 0; dly = 0;
      m_raddr = '0; m_fdata = '0; exp_rd = '0; pdata = '0;
    end else begin
      bit do_push, do_pop, racc, hit;
      logic [DW-1:0] hd;
      int nst;
      calc();
      if (d_mv && mem_req_ready) begin
        if (d_mw) bmem[int'(d_ma)] = d_md;
        else begin
          pend = 1; dly = LAT;
          pdata = bmem.exists(int'(d_ma)) ? bmem[int'(d_ma)] : '0;
        end
      end
      do_push = st_valid && e_st_ready;
      do_pop  = e_mv && e_mw && mem_req_ready;
      racc    = rd_valid && (m_st == 0);
      hit = 0; hd = '0;
      if (do_push) arch[int'(st_addr)] = st_data;
      if (racc) begin
        exp_rd = arch.exists(int'(rd_addr)) ? arch[int'(rd_addr)] : '0;
        for (int i = 0; i < q_a.size(); i++)
          if (q_a[i] == rd_addr) begin hit = 1; hd = q_d[i]; end
        if (do_push && st_addr == rd_addr) begin hit = 1; hd = st_data; end
      end
      nst = m_st;
      case (m_st)
        0: if (racc) nst = hit ? 1 : 2;
        1: nst = 0;
        2: if (mem_req_ready) nst = 3;
        default: if (mem_rsp_valid) nst = 0;
      endcase
      if (racc) begin m_raddr = rd_addr; m_fdata = hd; end
      if (do_pop) begin void'(q_a.pop_front()); void'(q_d.pop_front()); end
      if (do_push) begin q_a.push_back(st_addr); q_d.push_back(st_data); end
      m_st = nst;
    end
  end

  // memory response driver
  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_rsp_data  <= $urandom;
    if (pend) begin
      dly = dly - 1;
      if (dly == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= pdata;
        pend = 0;
      end
    end
  end

  // per-cycle comparison, away from both edges
  always @(negedge clk) begin
    #2;
    d_mv = mem_req_valid; d_mw = mem_req_write; d_ma = mem_req_addr; d_md = mem_req_wdata;
    if (rst_n && !done) begin
      calc();
      chk("R3 st_ready", st_ready, e_st_ready);
      chk("R8 rd_ready", rd_ready, e_rd_ready);
      chk((m_st == 3) ? "R9 mem_req_valid" : "R2 R4 mem_req_valid", mem_req_valid, e_mv);
      if (e_mv) begin
        chk("R4 mem_req_write", mem_req_write, e_mw);
        chk("R2 R4 mem_req_addr", mem_req_addr, e_ma);
        if (e_mw) chk("R2 mem_req_wdata", mem_req_wdata, e_md);
      end
      chk("R5 R7 rd_resp_valid", rd_resp_valid, e_rv);
      if (e_rv) chk("R5 R7 rd_resp_data", rd_resp_data, e_rd);
      if (e_rv && rd_resp_valid) chk("R10 latest stored value", rd_resp_data, exp_rd);
    end
  end

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); st_valid = 1; st_addr = a; st_data = d; #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(negedge clk); st_valid = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_valid = 1; rd_addr = a; #1;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(negedge clk); rd_valid = 0; #1;
    while (!rd_resp_valid) begin @(negedge clk); #1; end
    d = rd_resp_data;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1; nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    rst_n = 0; st_valid = 0; rd_valid = 0; mem_req_ready = 0;
    st_addr = '0; st_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 st_ready in reset", st_ready, 1);
    chk("R1 rd_ready in reset", rd_ready, 1);
    chk("R1 mem_req_valid in reset", mem_req_valid, 0);
    chk("R1 rd_resp_valid in reset", rd_resp_valid, 0);
    @(negedge clk); rst_n = 1;

    // fill with memory stalled
    for (int i = 1; i <= 4; i++) do_store(AW'(i), DW'(32'h100 + i));
    #1 chk("R3 full stalls", st_ready, 0);
    @(negedge clk); st_valid = 1; st_addr = 9; st_data = 32'h99;
    repeat (2) @(negedge clk); st_valid = 0; #1;
    chk("R3 still full after refused store", st_ready, 0);

    // forward while full, no memory access
    do_read(3, r);
    chk("R5 forward from buffer", r, 32'h103);

    // non-matching read overtakes pending writes
    @(negedge clk); rd_valid = 1; rd_addr = 7;
    @(negedge clk); rd_valid = 0; #1;
    chk("R4 read request valid", mem_req_valid, 1);
    chk("R4 read ahead of writes", mem_req_write, 0);
    chk("R4 read address", mem_req_addr, 7);
    repeat (2) @(negedge clk);
    #1 chk("R4 read held", mem_req_write, 0);
    mem_req_ready = 1;
    while (!rd_resp_valid) begin @(negedge clk); #1; end
    chk("R7 memory data returned", rd_resp_data, 0);
    repeat (6) @(negedge clk);

    // same-cycle store and read
    @(negedge clk); st_valid = 1; st_addr = 20; st_data = 32'hAA; rd_valid = 1; rd_addr = 20;
    @(negedge clk); st_valid = 0; rd_valid = 0; #1;
    chk("R6 same-cycle forward valid", rd_resp_valid, 1);
    chk("R6 same-cycle forward data", rd_resp_data, 32'hAA);

    // youngest of several matches
    @(negedge clk); mem_req_ready = 0;
    do_store(30, 1); do_store(30, 2); do_store(30, 3);
    do_read(30, r);
    chk("R5 youngest match", r, 3);
    mem_req_ready = 1;

    // conflicting index sequence
    do_store(512, 32'h5120);
    do_read(1024, r);
    chk("R10 conflicting read", r, 0);
    do_read(512, r);
    chk("R10 reload of stored word", r, 32'h5120);

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      mem_req_ready = ($urandom % 10) < 7;
      st_valid = $urandom % 2;
      st_addr = AW'($urandom % 8);
      st_data = $urandom;
      rd_valid = ($urandom % 3) == 0;
      rd_addr = AW'($urandom % 8);
    end
    @(negedge clk); st_valid = 0; rd_valid = 0; mem_req_ready = 1;
    repeat (30) @(negedge clk);
    foreach (arch[k])
      chk("R2 memory holds final store", bmem.exists(k) ? bmem[k] : 32'hDEAD_BEEF, arch[k]);
    chk("R3 refused store never written", bmem.exists(9), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule